// File: doc/BRIEF.md
# Triple Prescaled Interval Timer

This peripheral holds three independent 16-bit up-counters behind one 32-bit word register bus. Each counter has an optional power-of-two clock divider. It can run freely, wrapping past 0xFFFF, or it can return to zero after reaching a programmed limit. Three compare values can flag chosen counts. Events are latched in a per-counter status register that software clears by writing ones. Each counter drives a level interrupt, which is raised while any latched status bit is also enabled.

All three counters share one address window. A register of kind `k` (0..8) for counter `c` (0..2) sits at byte offset `12*k + 4*c`. The kinds are:

| k | Register |
|---|----------|
| 0 | clock control |
| 1 | counter control |
| 2 | count value |
| 3 | limit |
| 4..6 | compare 1..3 |
| 7 | status |
| 8 | enable |

Each counter has a two-state run controller. It is HALT after reset. A counter-control write with bit 0 clear takes the START transition to RUN. A counter-control write with bit 0 set takes the STOP transition back to HALT. Any other write leaves the state as it is.

Top module: `ttc3_timer`

## Requirements
- R1: The register at byte offset `12*k + 4*c` belongs to counter `c` and kind `k`, with kinds in the order given above. A write reaches only that counter's register. A read at any offset of 0x6C or above returns 0.
- R2: After reset, counter control reads 0x21 on every counter, and all other registers read 0. All interrupt outputs are low.
- R3: While running with the divider bypassed, the count rises by one on every clock.
- R4: Clock-control bit 0 enables the divider, and bits [4:1] hold N. The count then rises once every 2^(N+1) clocks, counted from the last restart. When bit 0 is clear, the divider is bypassed whatever N holds.
- R5: While counter-control bit 0 reads 1 (HALT), the count holds its value. Clearing the bit resumes counting from that value.
- R6: Writing 1 to counter-control bit 4 sets the count and the divider phase to zero. This also happens when the same write sets bit 0. Bit 4 always reads 0.
- R7: With counter-control bit 1 set, a count step taken while the count equals the limit returns the count to 0 and sets status bit 0.
- R8: With counter-control bit 1 clear, a step from 0xFFFF wraps the count to 0 and sets status bit 4.
- R9: With counter-control bit 3 set, a step taken while the count equals compare j (j = 1..3) sets status bit j. With bit 3 clear, these status bits are never set.
- R10: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. If an event sets a bit in the same cycle as a clearing write, the bit stays set.
- R11: Interrupt output c is high exactly when counter c has a status bit in [5:0] whose enable bit is also set.
- R12: Writes to the count-value register have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Byte address of the register word |
| bus_we | input | 1 | Write strobe, taken at the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 3 | Level interrupt, one per counter |

## Verification
Properties check on every cycle that the count is frozen in HALT unless a restart arrives, that a restart always gives a zero count, that a limit match wraps to zero and raises status bit 0, and that an event always leaves its status bit set even when it coincides with a clearing write. The bench scenarios cover the behaviour that only shows over many cycles or through the register map:
- the exact divider rates and the bypass case;
- overflow after a full 65536-step run;
- gating of compare events by the enable bit;
- isolation between counters in the address window;
- the read-only count register.

The bench also shows the set-versus-clear race from outside. It times a clearing write once on a divider tick and once between ticks.

// File: rtl/ttc_pkg.sv
package ttc_pkg;
    localparam int NUM_REG_KINDS = 9;
    localparam int NUM_MATCH     = 3;
    localparam int STAT_W        = 6;
    localparam int CTL_W         = 7;

    typedef enum logic [3:0] {
        RK_CLKCTL = 4'd0,
        RK_CNTCTL = 4'd1,
        RK_COUNT  = 4'd2,
        RK_LIMIT  = 4'd3,
        RK_CMP1   = 4'd4,
        RK_CMP2   = 4'd5,
        RK_CMP3   = 4'd6,
        RK_STAT   = 4'd7,
        RK_ENA    = 4'd8
    } reg_kind_e;

    typedef enum logic {
        CH_HALT = 1'b0,
        CH_RUN  = 1'b1
    } run_state_e;
endpackage

// File: rtl/ttc_divider.sv
module ttc_divider #(
    parameter int PSW = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           run,
    input  logic           restart,
    input  logic           bypass,
    input  logic [PSW-1:0] exp_n,
    output logic           tick
);
    localparam int PCW = (1 << PSW) + 1;

    logic [PCW-1:0] phase_q;
    logic [PCW-1:0] limit;
    logic           hit;

    // terminal phase is 2^(N+1)-1
    assign limit = (PCW'(2) << exp_n) - PCW'(1);
    assign hit   = (phase_q == limit);
    assign tick  = run && (bypass || hit);

    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            phase_q <= '0;
        end else if (run && !bypass) begin
            phase_q <= hit ? '0 : phase_q + PCW'(1);
        end
    end
endmodule

// File: rtl/ttc_channel.sv
module ttc_channel
    import ttc_pkg::*;
#(
    parameter int CW  = 16,
    parameter int PSW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  reg_kind_e     wr_kind,
    input  logic [CW-1:0] wdata,
    input  reg_kind_e     rd_kind,
    output logic [CW-1:0] rd_data,
    output logic          irq
);
    run_state_e          state_q, state_d;
    logic [PSW:0]        clkctl_q;
    logic [CTL_W-1:0]    ctl_q;
    logic [CW-1:0]       cnt_q;
    logic [CW-1:0]       limit_q;
    logic [CW-1:0]       cmp_q [NUM_MATCH];
    logic [STAT_W-1:0]   stat_q, ena_q, set_ev, clr_mask;
    logic [CTL_W-1:0]    ctl_rb;
    logic                wr_ctl, restart, tick, step, at_limit, at_top;

    assign wr_ctl  = wr_en && (wr_kind == RK_CNTCTL);
    assign restart = wr_ctl && wdata[4];

    // run controller: START / STOP transitions
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CH_HALT;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_HALT: if (wr_ctl && !wdata[0]) state_d = CH_RUN;
            CH_RUN:  if (wr_ctl &&  wdata[0]) state_d = CH_HALT;
        endcase
    end

    ttc_divider #(.PSW(PSW)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (state_q == CH_RUN),
        .restart (restart),
        .bypass  (!clkctl_q[0]),
        .exp_n   (clkctl_q[PSW:1]),
        .tick    (tick)
    );

    assign step     = tick && !restart;
    assign at_limit = ctl_q[1] && (cnt_q == limit_q);
    assign at_top   = !ctl_q[1] && (cnt_q == {CW{1'b1}});

    always_ff @(posedge clk) begin
        if (!rst_n || restart) cnt_q <= '0;
        else if (step)         cnt_q <= at_limit ? '0 : cnt_q + CW'(1);
    end

    // plain configuration registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clkctl_q <= '0;
            ctl_q    <= CTL_W'(7'h20);
            limit_q  <= '0;
            ena_q    <= '0;
        end else if (wr_en) begin
            unique case (wr_kind)
                RK_CLKCTL: clkctl_q <= wdata[PSW:0];
                RK_CNTCTL: ctl_q    <= wdata[CTL_W-1:0];
                RK_LIMIT:  limit_q  <= wdata;
                RK_ENA:    ena_q    <= wdata[STAT_W-1:0];
                default:   ;
            endcase
        end
    end

    for (genvar m = 0; m < NUM_MATCH; m++) begin : g_cmp
        always_ff @(posedge clk) begin
            if (!rst_n)
                cmp_q[m] <= '0;
            else if (wr_en && (wr_kind == reg_kind_e'(4'(int'(RK_CMP1) + m))))
                cmp_q[m] <= wdata;
        end
        assign set_ev[m+1] = step && ctl_q[3] && (cnt_q == cmp_q[m]);
    end

    assign set_ev[0] = step && at_limit;
    assign set_ev[4] = step && at_top;
    assign set_ev[5] = 1'b0;

    assign clr_mask = (wr_en && (wr_kind == RK_STAT)) ? wdata[STAT_W-1:0] : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= (stat_q & ~clr_mask) | set_ev;
    end

    assign irq    = |(stat_q & ena_q);
    assign ctl_rb = {ctl_q[6:5], 1'b0, ctl_q[3:1], state_q == CH_HALT};

    always_comb begin
        case (rd_kind)
            RK_CLKCTL: rd_data = CW'(clkctl_q);
            RK_CNTCTL: rd_data = CW'(ctl_rb);
            RK_COUNT:  rd_data = cnt_q;
            RK_LIMIT:  rd_data = limit_q;
            RK_CMP1:   rd_data = cmp_q[0];
            RK_CMP2:   rd_data = cmp_q[1];
            RK_CMP3:   rd_data = cmp_q[2];
            RK_STAT:   rd_data = CW'(stat_q);
            RK_ENA:    rd_data = CW'(ena_q);
            default:   rd_data = '0;
        endcase
    end

    // R5: halted count is frozen unless restarted
    a_r5_halt_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_HALT && !restart) |=> $stable(cnt_q));
    // R6: restart always yields a zero count
    a_r6_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (cnt_q == '0));
    // R7: limit match wraps to zero and flags
    a_r7_limit_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !restart && ctl_q[1] && cnt_q == limit_q) |=> (cnt_q == '0 && stat_q[0]));
    // R10: an event wins over a same-cycle clear
    a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        set_ev[0] |=> stat_q[0]);
    // R8: overflow step leaves status bit 4 set
    a_r8_overflow_flag: assert property (@(posedge clk) disable iff (!rst_n)
        set_ev[4] |=> (stat_q[4] && cnt_q == '0));
endmodule

// File: rtl/ttc3_timer.sv
module ttc3_timer
    import ttc_pkg::*;
#(
    parameter int NUM_CH = 3,
    parameter int CW     = 16,
    parameter int PSW    = 4,
    parameter int AW     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [NUM_CH-1:0] irq
);
    localparam int WW = AW - 2;

    logic [WW-1:0]  word, kind_raw, ch_raw;
    logic           in_map;
    reg_kind_e      kind;
    logic [CW-1:0]  ch_rd [NUM_CH];
    logic           unused_bits;

    // interleaved window: word index = kind * NUM_CH + channel
    assign word     = bus_addr[AW-1:2];
    assign kind_raw = word / WW'(NUM_CH);
    assign ch_raw   = word % WW'(NUM_CH);
    assign in_map   = kind_raw < WW'(NUM_REG_KINDS);
    assign kind     = reg_kind_e'(kind_raw[3:0]);

    assign unused_bits = &{1'b0, bus_addr[1:0], bus_wdata[31:CW]};

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        ttc_channel #(.CW(CW), .PSW(PSW)) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (bus_we && in_map && (ch_raw == WW'(i))),
            .wr_kind (kind),
            .wdata   (bus_wdata[CW-1:0]),
            .rd_kind (kind),
            .rd_data (ch_rd[i]),
            .irq     (irq[i])
        );
    end

    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (in_map && (ch_raw == WW'(i))) bus_rdata = 32'(ch_rd[i]);
        end
    end
endmodule

// File: tb/ttc3_timer_tb.sv
module ttc3_timer_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [2:0]  irq;
    logic        rd_req = 1'b0;
    bit          done = 1'b0;
    int          checks = 0;
    int          errors = 0;

    typedef struct {
        bit          is_irq;
        logic [31:0] exp;
        string       tag;
    } exp_t;
    exp_t exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    ttc3_timer u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    function automatic logic [7:0] ra(input int kind, input int ch);
        return 8'(12 * kind + 4 * ch);
    endfunction

    // monitor: pops expected items and compares against the design
    always @(negedge clk) begin
        exp_t        e;
        logic [31:0] act;
        if (rd_req && exp_q.size() > 0) begin
            e = exp_q.pop_front();
            act = e.is_irq ? 32'(irq) : bus_rdata;
            checks++;
            if (act !== e.exp) begin
                errors++;
                $display("FAIL %s: actual 0x%0h expected 0x%0h", e.tag, act, e.exp);
            end
        end
    end

    task automatic push(input bit is_irq, input logic [31:0] exp, input string tag);
        exp_t e;
        e.is_irq = is_irq; e.exp = exp; e.tag = tag;
        exp_q.push_back(e);
        rd_req = 1'b1;
        @(negedge clk);
        #1 rd_req = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
        @(posedge clk); #1;
        bus_addr = a;
        push(1'b0, exp, tag);
    endtask

    task automatic irq_chk(input logic [2:0] exp, input string tag);
        @(posedge clk); #1;
        push(1'b1, 32'(exp), tag);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(posedge clk); #1;
        bus_we = 1'b0;
    endtask

    // write, then read the same address right after the capturing edge
    task automatic wr_rd(input logic [7:0] a, input logic [31:0] d,
                         input logic [31:0] exp, input string tag);
        @(posedge clk); #1;
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(posedge clk); #1;
        bus_we = 1'b0;
        push(1'b0, exp, tag);
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog (all requirements): actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R2 reset state
        for (int c = 0; c < 3; c++) rd(ra(1, c), 32'h21, "R2 counter control reset");
        rd(ra(0, 1), 32'h0, "R2 clock control reset");
        rd(ra(2, 2), 32'h0, "R2 count reset");
        irq_chk(3'b000, "R2 irq reset");

        // R1 map isolation and out-of-range
        wr(ra(3, 1), 32'h1234);
        rd(ra(3, 0), 32'h0, "R1 counter0 limit untouched");
        rd(ra(3, 1), 32'h1234, "R1 counter1 limit");
        rd(ra(3, 2), 32'h0, "R1 counter2 limit untouched");
        rd(8'h6C, 32'h0, "R1 out-of-range read");

        // R3 free run, R6 restart
        wr(ra(1, 0), 32'h10); idle(6); wr(ra(1, 0), 32'h01);
        rd(ra(2, 0), 32'd8, "R3 count after 8 clocks");
        rd(ra(1, 0), 32'h01, "R5 halt reads bit0");
        rd(ra(7, 0), 32'h0, "R3 no status from free run");
        // R5 hold and resume
        idle(10);
        rd(ra(2, 0), 32'd8, "R5 halted count holds");
        wr(ra(1, 0), 32'h00); idle(2); wr(ra(1, 0), 32'h01);
        rd(ra(2, 0), 32'd12, "R5 resume from held value");
        // R12 read-only count
        wr(ra(2, 0), 32'h55);
        rd(ra(2, 0), 32'd12, "R12 count write ignored");
        // R6 restart with disable, bit4 reads 0
        wr(ra(1, 0), 32'h11);
        rd(ra(2, 0), 32'd0, "R6 restart while disabling");
        rd(ra(1, 0), 32'h01, "R6 restart bit reads 0");

        // R4 divider
        wr(ra(0, 1), 32'h01);
        wr(ra(1, 1), 32'h10); idle(8); wr(ra(1, 1), 32'h01);
        rd(ra(2, 1), 32'd5, "R4 divide by 2");
        wr(ra(0, 1), 32'h05);
        wr(ra(1, 1), 32'h10); idle(14); wr(ra(1, 1), 32'h01);
        rd(ra(2, 1), 32'd2, "R4 divide by 8");
        wr(ra(0, 1), 32'h04);
        wr(ra(1, 1), 32'h10); idle(2); wr(ra(1, 1), 32'h01);
        rd(ra(2, 1), 32'd4, "R4 bypass ignores N");

        // R9 compare events
        wr(ra(0, 1), 32'h00);
        wr(ra(4, 1), 32'd5); wr(ra(5, 1), 32'd100); wr(ra(6, 1), 32'd7);
        wr(ra(1, 1), 32'h18); idle(6); wr(ra(1, 1), 32'h09);
        rd(ra(2, 1), 32'd8, "R9 count at compare test");
        rd(ra(7, 1), 32'h0A, "R9 compare 1 and 3 flagged");
        wr_rd(ra(7, 1), 32'h0A, 32'h0, "R10 write-one clears compare flags");
        wr(ra(1, 1), 32'h10); idle(6); wr(ra(1, 1), 32'h01);
        rd(ra(7, 1), 32'h0, "R9 compare gated off");

        // R7 limit mode, R11 irq
        wr(ra(3, 2), 32'd3); wr(ra(8, 2), 32'h01);
        wr(ra(1, 2), 32'h12); idle(3); wr(ra(1, 2), 32'h03);
        rd(ra(2, 2), 32'd1, "R7 count wrapped at limit");
        rd(ra(7, 2), 32'h01, "R7 limit status");
        irq_chk(3'b100, "R11 irq for counter 2 only");
        wr_rd(ra(7, 2), 32'h01, 32'h0, "R10 acknowledge");
        irq_chk(3'b000, "R11 irq drops after ack");
        wr(ra(8, 2), 32'h00);
        wr(ra(1, 2), 32'h12); idle(3); wr(ra(1, 2), 32'h03);
        rd(ra(7, 2), 32'h01, "R7 status with enable off");
        irq_chk(3'b000, "R11 masked status gives no irq");
        wr(ra(7, 2), 32'h01);

        // R10 set wins over clear, probed on and off a tick
        wr(ra(0, 2), 32'h01); wr(ra(3, 2), 32'd0);
        wr(ra(1, 2), 32'h12); idle(2);
        wr_rd(ra(7, 2), 32'h01, 32'h01, "R10 set in clearing cycle stays");
        wr(ra(1, 2), 32'h12); idle(1);
        wr_rd(ra(7, 2), 32'h01, 32'h00, "R10 clear between ticks");
        wr(ra(1, 2), 32'h03);

        // R8 overflow
        wr(ra(8, 0), 32'h10);
        wr(ra(1, 0), 32'h10); idle(65534); wr(ra(1, 0), 32'h01);
        rd(ra(2, 0), 32'd0, "R8 count wrapped");
        rd(ra(7, 0), 32'h10, "R8 overflow status");
        irq_chk(3'b001, "R11 overflow irq");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule